// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Bank

This block watches a set of general-purpose input pins, grouped into banks of equal width, and turns selected transitions on them into interrupt requests. Each pin first passes through a two-stage synchronizer. A per-pin trigger code then picks the transitions that count: none, rising, falling, or both. A qualifying transition sets a sticky bit in the status word of that pin's bank.

Software clears status bits by writing ones to them. Masking uses two write ports. Writing ones to the mask-set word hides those pins, and writing ones to the mask-clear word exposes them. Each bank drives one interrupt line, and that line is high whenever the bank has a latched event on a pin that is not masked. There is no level-sensitive mode.

The block sits on a simple single-cycle write port and a combinational read port. It is meant to be placed next to a pad ring, with one interrupt line per bank routed to the system interrupt controller.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Every pin passes through two synchronizing flops and one history flop. A pin change driven before clock edge E1 sets its status bit at edge E3 and not before.
- R2: Trigger code 1 latches a rising transition only.
- R3: Trigger code 2 latches a falling transition only.
- R4: Trigger code 3 latches both rising and falling transitions.
- R5: Trigger code 0 disables the pin, so no transition ever sets its status bit.
- R6: Writing to the bank status word (0x80 + 4*bank) clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R7: Writing to the mask-set word (0xA0 + 4*bank) masks the pins written as 1 and leaves the other mask bits unchanged.
- R8: Writing to the mask-clear word (0xC0 + 4*bank) unmasks the pins written as 1 and leaves the other mask bits unchanged.
- R9: A bank's interrupt output is high exactly when that bank has a status bit set whose mask bit is clear. It follows a mask or status change on the next clock edge.
- R10: After reset every mask bit is 1, every status bit is 0, every trigger code is 0 and every interrupt output is low.
- R11: If a transition is latched in the same cycle that a clear write hits the same bit, the bit stays set. Other bits in that write are still cleared.
- R12: The per-pin control word sits at 0x100 + 4*pin. Its trigger code is bits [4:3] and all other bits are ignored. Reads return the status word at 0x80 + 4*bank, the mask at 0xA0 + 4*bank, and the control word at 0x100 + 4*pin with only bits [4:3] non-zero. Any other address reads as zero.
- R13: Masked pins still latch their transitions into status. Masking gates only the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_BANKS*BANK_PINS | Asynchronous pin inputs, bank 0 in the low bits |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | DATA_W | Read data |
| irq_o | output | NUM_BANKS | One interrupt line per bank |

## Verification
A software clear of a status bit and a new transition on the same pin can land in the same cycle. The bench provokes this by toggling a pin and then timing a clear write so that its clock edge is the third edge after the change, which is the edge at which the transition latches. The bit must read back as set afterwards, while a second bit cleared in the same write must read back as zero. Mask writes and interrupt behaviour are also interleaved with random pin activity and random trigger codes, and each result is compared with a bench model.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    // Per-pin transition selection; bit 0 = rising, bit 1 = falling
    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_e;

    localparam int unsigned STAT_BASE  = 32'h080;
    localparam int unsigned MSET_BASE  = 32'h0A0;
    localparam int unsigned MCLR_BASE  = 32'h0C0;
    localparam int unsigned CTRL_BASE  = 32'h100;
    localparam int unsigned REG_STRIDE = 4;
    localparam int unsigned TRIG_LSB   = 3;
    localparam int unsigned TRIG_W     = 2;

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = pin_i;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.stable & ~st_q.prev;
    assign fall_o = ~st_q.stable & st_q.prev;

endmodule

// File: rtl/edge_irq_cfg.sv
module edge_irq_cfg
    import edge_irq_pkg::*;
#(
    parameter int unsigned NPINS  = 64,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [TRIG_W-1:0]     wr_code,
    output logic [TRIG_W*NPINS-1:0] trig_o
);

    typedef struct packed {
        logic [NPINS-1:0][TRIG_W-1:0] code;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int p = 0; p < NPINS; p++) begin
            if (wr_en && wr_addr == ADDR_W'(CTRL_BASE + REG_STRIDE * p))
                cfg_d.code[p] = wr_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign trig_o = cfg_q.code;

endmodule

// File: rtl/edge_irq_slice.sv
module edge_irq_slice
    import edge_irq_pkg::*;
#(
    parameter int unsigned PW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PW-1:0]      rise_i,
    input  logic [PW-1:0]      fall_i,
    input  logic [TRIG_W*PW-1:0] trig_i,
    input  logic               ack_we,
    input  logic               mask_we,
    input  logic               unmask_we,
    input  logic [PW-1:0]      wr_bits,
    output logic [PW-1:0]      status_o,
    output logic [PW-1:0]      mask_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [PW-1:0] status;
        logic [PW-1:0] mask;
    } slice_t;

    slice_t st_d, st_q;
    logic [PW-1:0] evt;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            unique case (trig_e'(trig_i[TRIG_W*i +: TRIG_W]))
                TRIG_RISE: evt[i] = rise_i[i];
                TRIG_FALL: evt[i] = fall_i[i];
                TRIG_BOTH: evt[i] = rise_i[i] | fall_i[i];
                default:   evt[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        // a fresh event wins over a simultaneous clear
        st_d.status = (st_q.status & ~(ack_we ? wr_bits : '0)) | evt;
        if (mask_we)
            st_d.mask = st_q.mask | wr_bits;
        else if (unmask_we)
            st_d.mask = st_q.mask & ~wr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.status & ~st_q.mask);

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned BANK_PINS = 32,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_BANKS*BANK_PINS-1:0] pins_i,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    output logic [NUM_BANKS-1:0]           irq_o
);

    localparam int unsigned NPINS = NUM_BANKS * BANK_PINS;

    logic [NPINS-1:0]        rise_all, fall_all;
    logic [TRIG_W*NPINS-1:0] trig_all;
    logic [NPINS-1:0]        status_all, mask_all;

    edge_irq_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins_i),
        .rise_o (rise_all),
        .fall_o (fall_all)
    );

    edge_irq_cfg #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_code (wr_data[TRIG_LSB +: TRIG_W]),
        .trig_o  (trig_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_BASE + REG_STRIDE * b);
        localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(MSET_BASE + REG_STRIDE * b);
        localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(MCLR_BASE + REG_STRIDE * b);

        edge_irq_slice #(.PW(BANK_PINS)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .rise_i    (rise_all[b*BANK_PINS +: BANK_PINS]),
            .fall_i    (fall_all[b*BANK_PINS +: BANK_PINS]),
            .trig_i    (trig_all[TRIG_W*b*BANK_PINS +: TRIG_W*BANK_PINS]),
            .ack_we    (wr_en && wr_addr == A_STAT),
            .mask_we   (wr_en && wr_addr == A_MSET),
            .unmask_we (wr_en && wr_addr == A_MCLR),
            .wr_bits   (wr_data[BANK_PINS-1:0]),
            .status_o  (status_all[b*BANK_PINS +: BANK_PINS]),
            .mask_o    (mask_all[b*BANK_PINS +: BANK_PINS]),
            .irq_o     (irq_o[b])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_addr == ADDR_W'(STAT_BASE + REG_STRIDE * b))
                rd_data = DATA_W'(status_all[b*BANK_PINS +: BANK_PINS]);
            if (rd_addr == ADDR_W'(MSET_BASE + REG_STRIDE * b))
                rd_data = DATA_W'(mask_all[b*BANK_PINS +: BANK_PINS]);
        end
        for (int p = 0; p < NPINS; p++) begin
            if (rd_addr == ADDR_W'(CTRL_BASE + REG_STRIDE * p))
                rd_data[TRIG_LSB +: TRIG_W] = trig_all[TRIG_W*p +: TRIG_W];
        end
    end

endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk
    import edge_irq_pkg::*;
#(
    parameter int unsigned NB     = 2,
    parameter int unsigned PW     = 32,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [DATA_W-1:0]    wr_data,
    input logic [NB*PW-1:0]     status_all,
    input logic [NB*PW-1:0]     mask_all,
    input logic [TRIG_W*NB*PW-1:0] trig_all,
    input logic [NB-1:0]        irq_o
);

    for (genvar b = 0; b < NB; b++) begin : g_b
        localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_BASE + REG_STRIDE * b);
        localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(MSET_BASE + REG_STRIDE * b);
        localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(MCLR_BASE + REG_STRIDE * b);

        // R6
        status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == A_STAT) |=>
            ((status_all[b*PW +: PW] & $past(status_all[b*PW +: PW])) == $past(status_all[b*PW +: PW])));

        // R7
        mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_MSET) |=>
            ((mask_all[b*PW +: PW] & $past(wr_data[PW-1:0])) == $past(wr_data[PW-1:0])));

        // R8
        mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_MCLR) |=>
            ((mask_all[b*PW +: PW] & $past(wr_data[PW-1:0])) == '0));

        // R9
        irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (&mask_all[b*PW +: PW]) |-> !irq_o[b]);

        // R9
        irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[b] |-> (status_all[b*PW +: PW] != '0));
    end

    for (genvar p = 0; p < NB*PW; p++) begin : g_p
        // R5
        off_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_all[p]) |-> ($past(trig_all[TRIG_W*p +: TRIG_W]) != 2'd0));
    end

endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(
    .NB(NUM_BANKS), .PW(BANK_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .status_all (status_all),
    .mask_all   (mask_all),
    .trig_all   (trig_all),
    .irq_o      (irq_o)
);

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int PW = 32;
    localparam int NP = NB * PW;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NB-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [PW-1:0] m_stat [NB];
    logic [PW-1:0] m_mask [NB];
    logic [1:0]    m_trig [NP];
    logic [NP-1:0] m_pins;

    edge_irq_ctrl #(.NUM_BANKS(NB), .BANK_PINS(PW), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] a_stat(int b); return AW'(32'h80 + 4*b); endfunction
    function automatic logic [AW-1:0] a_mset(int b); return AW'(32'hA0 + 4*b); endfunction
    function automatic logic [AW-1:0] a_mclr(int b); return AW'(32'hC0 + 4*b); endfunction
    function automatic logic [AW-1:0] a_ctrl(int p); return AW'(32'h100 + 4*p); endfunction

    function automatic logic [NP-1:0] hits(input logic [NP-1:0] o, input logic [NP-1:0] n);
        logic [NP-1:0] h;
        for (int p = 0; p < NP; p++) begin
            case (m_trig[p])
                2'd1:    h[p] = ~o[p] & n[p];
                2'd2:    h[p] = o[p] & ~n[p];
                2'd3:    h[p] = o[p] ^ n[p];
                default: h[p] = 1'b0;
            endcase
        end
        return h;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_trig(input int p, input logic [1:0] c);
        bus_wr(a_ctrl(p), 32'hFFFF_FFE7 | (DW'(c) << 3));
        m_trig[p] = c;
    endtask

    task automatic ack(input int b, input logic [PW-1:0] d);
        bus_wr(a_stat(b), DW'(d));
        m_stat[b] &= ~d;
    endtask

    task automatic mset(input int b, input logic [PW-1:0] d);
        bus_wr(a_mset(b), DW'(d));
        m_mask[b] |= d;
    endtask

    task automatic mclr(input int b, input logic [PW-1:0] d);
        bus_wr(a_mclr(b), DW'(d));
        m_mask[b] &= ~d;
    endtask

    task automatic drive_pins(input logic [NP-1:0] v);
        logic [NP-1:0] h;
        h = hits(m_pins, v);
        @(negedge clk);
        pins = v;
        m_pins = v;
        repeat (3) @(negedge clk);
        for (int b = 0; b < NB; b++) m_stat[b] |= h[b*PW +: PW];
    endtask

    task automatic check_all(input string req);
        logic [DW-1:0] d;
        for (int b = 0; b < NB; b++) begin
            bus_rd(a_stat(b), d);
            chk({req, " status"}, d, DW'(m_stat[b]));
            bus_rd(a_mset(b), d);
            chk({req, " mask"}, d, DW'(m_mask[b]));
            chk({req, " R9 irq"}, DW'(irq[b]), DW'(|(m_stat[b] & ~m_mask[b])));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd61803));
        for (int b = 0; b < NB; b++) begin m_stat[b] = '0; m_mask[b] = '1; end
        for (int p = 0; p < NP; p++) m_trig[p] = 2'd0;
        m_pins = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check_all("R10");
        bus_rd(a_ctrl(7), d);
        chk("R10 ctrl", d, 32'h0);
        chk("R10 irq", DW'(irq), '0);

        // R12 control field position and ignored bits
        set_trig(5, 2'd1);
        set_trig(40, 2'd3);
        bus_rd(a_ctrl(5), d);
        chk("R12 ctrl pin5", d, 32'h08);
        bus_rd(a_ctrl(40), d);
        chk("R12 ctrl pin40", d, 32'h18);
        bus_rd(a_mclr(0), d);
        chk("R12 mclr reads zero", d, 32'h0);
        bus_rd(AW'(12'h7FC), d);
        chk("R12 unmapped reads zero", d, 32'h0);

        // R1 latency: change before E1, set at E3
        @(negedge clk);
        pins[5] = 1'b1;
        m_pins[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_rd(a_stat(0), d);
        chk("R1 not yet after E2", d, 32'h0);
        @(negedge clk);
        bus_rd(a_stat(0), d);
        chk("R1 set after E3", d, 32'h20);
        m_stat[0][5] = 1'b1;
        ack(0, 32'h20);

        // R2 R3 R4 R5 per-code behaviour on pins 0..3 (codes 0..3)
        for (int p = 0; p < 4; p++) set_trig(p, 2'(p));
        drive_pins(m_pins | 64'hF);
        bus_rd(a_stat(0), d);
        chk("R2 R4 R5 rising", d & 32'hF, 32'hA);
        ack(0, '1);
        drive_pins(m_pins & ~64'hF);
        bus_rd(a_stat(0), d);
        chk("R3 R4 R5 falling", d & 32'hF, 32'hC);

        // R13 masked pins latch, R9 irq follows unmask
        chk("R13 masked irq low", DW'(irq[0]), 32'h0);
        mclr(0, 32'h4);
        chk("R9 irq on unmask", DW'(irq[0]), 32'h1);
        mset(0, 32'h4);
        chk("R7 irq off on mask", DW'(irq[0]), 32'h0);
        mclr(0, 32'h0000_0011);
        bus_rd(a_mset(0), d);
        chk("R8 partial unmask", d, 32'hFFFF_FFEE);
        mset(0, 32'h0000_0001);
        bus_rd(a_mset(0), d);
        chk("R7 partial mask", d, 32'hFFFF_FFEF);

        // R6 partial write-one-to-clear
        ack(0, 32'h4);
        bus_rd(a_stat(0), d);
        chk("R6 partial clear", d & 32'hF, 32'h8);

        // R11 edge coincides with clear of same bit; bit 3 cleared in same write
        @(negedge clk);
        pins[1] = 1'b1;
        m_pins[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a_stat(0); wr_data = 32'h0000_000A;
        @(negedge clk);
        wr_en = 1'b0;
        bus_rd(a_stat(0), d);
        chk("R11 coincident edge kept", d & 32'hF, 32'h2);
        m_stat[0] = d[PW-1:0];
        check_all("R11");

        // random phase
        for (int it = 0; it < 40; it++) begin
            for (int k = 0; k < 6; k++) set_trig(int'($urandom_range(NP-1, 0)), 2'($urandom_range(3, 0)));
            drive_pins(m_pins ^ {$urandom(), $urandom()});
            case ($urandom_range(3, 0))
                0: ack(int'($urandom_range(NB-1, 0)), $urandom());
                1: mset(int'($urandom_range(NB-1, 0)), $urandom());
                2: mclr(int'($urandom_range(NB-1, 0)), $urandom());
                default: ;
            endcase
            check_all("R2 R3 R4 R5 R6 R7 R8 R13 random");
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule